// File: doc/BRIEF.md
# Digital Potentiometer Wiper Controller

This block keeps the wiper position for one or two resistor-ladder channels and converts each stored 8-bit code into switch enables for the ladder. Each channel has 256 tap positions, and each channel drives its own bank of tap-select outputs. Exactly one tap is enabled at a time. Code zero closes the tap at the B-terminal contact. Each larger code moves the selection one tap toward terminal A. The top ladder segment is never chosen.

A host loads and reads the wiper latches through a small synchronous register port. Two general-purpose logic output bits are loaded and read through the same port. A shutdown input puts every channel into a low-power state. In that state:
- the terminal-A switch opens;
- a dedicated switch ties the wiper to terminal B;
- all tap selects turn off.

The stored codes stay intact during shutdown. On release, the taps return to the stored codes with no rewrite.

Top module: `wiper_ctrl_top`

## Requirements
- R1: While `rst` is high at a clock edge, every wiper latch loads midscale (0x80), `gpo` clears to 0, and each channel's tap vector shows only bit 128 set, with `term_a_en` high and `shdn_sw_en` low.
- R2: A write (`wr_en` high) to address 0 or 1 loads channel 0 or 1's latch at that clock edge. The channel's tap vector follows one edge later.
- R3: Tap-select bit i (bit `ch*256+i` of `tap_sel`) is set when the channel's code equals i. Code 0x00 selects bit 0, the B-side contact, and code 0xFF selects bit 255.
- R4: At every edge where `shdn` is high, all tap bits of every channel clear, `term_a_en` goes low and `shdn_sw_en` goes high.
- R5: Shutdown leaves the latch contents unchanged. At the first edge after `shdn` falls, each tap vector again decodes the stored code.
- R6: A write made during shutdown updates the latch and its readback, but the taps stay off until shutdown is released.
- R7: A write to address 2 loads `wr_data[1:0]` into `gpo` at that edge and ignores the upper data bits. A read of address 2 returns `gpo` zero-extended to 8 bits.
- R8: `rd_data` is registered and shows, one edge after `reg_addr` is presented, the register at that address: 0 and 1 give the channel codes, 2 gives `gpo`, and 3 gives zero. Writes to address 3, or to address 1 in a one-channel build, change nothing.
- R9: A write to one channel leaves the other channel's latch and taps unchanged.
- R10: Outside shutdown, each channel's tap vector has exactly one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn | input | 1 | Shutdown request |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered readback data |
| gpo | output | 2 | General-purpose logic outputs |
| tap_sel | output | CHANNELS*256 | One-hot tap selects, channel 0 in the low 256 bits |
| term_a_en | output | CHANNELS | Terminal-A switch enable per channel |
| shdn_sw_en | output | CHANNELS | Wiper-to-B shutdown switch enable per channel |

## Verification
The decode is driven with the two end codes, 0x00 and 0xFF, and with a mid-range pattern (0x5A) on the second channel. The end codes expose any off-by-one or reversed tap ordering. The pattern on the second channel exposes crosstalk between the latches. The tap vector is sampled both at the write edge and one edge later, which separates correct one-cycle latency from a missing or extra register. Shutdown is entered with and without a write inside it. This shows whether shutdown clears the stored code or merely masks it, and whether a write during shutdown leaks to the taps early.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  // Register addresses; channel latches sit at their channel index.
  typedef enum logic [1:0] {
    ADDR_CH0  = 2'd0,
    ADDR_CH1  = 2'd1,
    ADDR_GPO  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  // Midscale code for a code width w: only the top bit set.
  function automatic int unsigned midscale(int unsigned w);
    return 32'd1 << (w - 1);
  endfunction
endpackage

// File: rtl/wiper_regs.sv
module wiper_regs
  import wiper_pkg::*;
#(
  parameter int CHANNELS = 2,
  parameter int CODE_W   = 8,
  parameter int GPO_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [1:0]                 reg_addr,
  input  logic [CODE_W-1:0]          wr_data,
  output logic [CHANNELS*CODE_W-1:0] codes,
  output logic [GPO_W-1:0]           gpo,
  output logic [CODE_W-1:0]          rd_data
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(midscale(CODE_W));

  // One latch per channel, addressed by channel index.
  for (genvar c = 0; c < CHANNELS; c++) begin : g_latch
    always_ff @(posedge clk) begin
      if (rst) begin
        codes[c*CODE_W +: CODE_W] <= MID;
      end else if (wr_en && (int'(reg_addr) == c)) begin
        codes[c*CODE_W +: CODE_W] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gpo <= '0;
    end else if (wr_en && (reg_addr == ADDR_GPO)) begin
      gpo <= wr_data[GPO_W-1:0];
    end
  end

  logic [CODE_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < CHANNELS; c++) begin
      if (int'(reg_addr) == c) rd_mux = codes[c*CODE_W +: CODE_W];
    end
    if (reg_addr == ADDR_GPO) rd_mux = CODE_W'(gpo);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/tap_decoder.sv
module tap_decoder
  import wiper_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shdn,
  input  logic [CODE_W-1:0]      code,
  output logic [(1<<CODE_W)-1:0] tap_sel,
  output logic                   term_a_en,
  output logic                   shdn_sw_en
);
  localparam int TAPS = 1 << CODE_W;
  localparam int MID  = int'(midscale(CODE_W));

  // One comparator per tap; shutdown gates every tap off.
  logic [TAPS-1:0] tap_nxt;
  always_comb begin
    for (int i = 0; i < TAPS; i++) begin
      tap_nxt[i] = (code == CODE_W'(i)) && !shdn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_sel      <= '0;
      tap_sel[MID] <= 1'b1;
      term_a_en    <= 1'b1;
      shdn_sw_en   <= 1'b0;
    end else begin
      tap_sel    <= tap_nxt;
      term_a_en  <= !shdn;
      shdn_sw_en <= shdn;
    end
  end
endmodule

// File: rtl/wiper_ctrl_top.sv
module wiper_ctrl_top
  import wiper_pkg::*;
#(
  parameter int CHANNELS = 2,
  parameter int CODE_W   = 8,
  parameter int GPO_W    = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                shdn,
  input  logic                                wr_en,
  input  logic [1:0]                          reg_addr,
  input  logic [CODE_W-1:0]                   wr_data,
  output logic [CODE_W-1:0]                   rd_data,
  output logic [GPO_W-1:0]                    gpo,
  output logic [CHANNELS*(1<<CODE_W)-1:0]     tap_sel,
  output logic [CHANNELS-1:0]                 term_a_en,
  output logic [CHANNELS-1:0]                 shdn_sw_en
);
  localparam int TAPS = 1 << CODE_W;

  logic [CHANNELS*CODE_W-1:0] codes;

  wiper_regs #(
    .CHANNELS(CHANNELS),
    .CODE_W  (CODE_W),
    .GPO_W   (GPO_W)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .reg_addr(reg_addr),
    .wr_data (wr_data),
    .codes   (codes),
    .gpo     (gpo),
    .rd_data (rd_data)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    tap_decoder #(
      .CODE_W(CODE_W)
    ) dec_i (
      .clk       (clk),
      .rst       (rst),
      .shdn      (shdn),
      .code      (codes[c*CODE_W +: CODE_W]),
      .tap_sel   (tap_sel[c*TAPS +: TAPS]),
      .term_a_en (term_a_en[c]),
      .shdn_sw_en(shdn_sw_en[c])
    );
  end
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk
  import wiper_pkg::*;
#(
  parameter int CHANNELS = 2,
  parameter int CODE_W   = 8,
  parameter int GPO_W    = 2
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            shdn,
  input logic                            wr_en,
  input logic [1:0]                      reg_addr,
  input logic [CODE_W-1:0]               wr_data,
  input logic [GPO_W-1:0]                gpo,
  input logic [CHANNELS*(1<<CODE_W)-1:0] tap_sel,
  input logic [CHANNELS-1:0]             term_a_en,
  input logic [CHANNELS-1:0]             shdn_sw_en
);
  localparam int TAPS = 1 << CODE_W;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chk
    // R10: outside shutdown exactly one tap is selected
    a_r10_one_tap: assert property (@(posedge clk) disable iff (rst)
      (!$past(shdn) && !$past(rst)) |-> ($countones(tap_sel[c*TAPS +: TAPS]) == 1));

    // R4: shutdown opens all taps and terminal A, closes wiper-to-B switch
    a_r4_shdn_state: assert property (@(posedge clk) disable iff (rst)
      ($past(shdn) && !$past(rst)) |->
        (tap_sel[c*TAPS +: TAPS] == '0 && !term_a_en[c] && shdn_sw_en[c]));

    // R5: after release the terminal switches return to normal
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
      (!$past(shdn) && !$past(rst)) |-> (term_a_en[c] && !shdn_sw_en[c]));
  end

  // R7: a write to the logic-output address loads the low data bits
  a_r7_gpo_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_addr == ADDR_GPO) |=> (gpo == $past(wr_data[GPO_W-1:0])));

  // R7: without such a write the logic outputs hold
  a_r7_gpo_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && reg_addr == ADDR_GPO) |=> $stable(gpo));
endmodule

bind wiper_ctrl_top wiper_ctrl_chk #(
  .CHANNELS(CHANNELS),
  .CODE_W  (CODE_W),
  .GPO_W   (GPO_W)
) chk_i (.*);

// File: tb/wiper_ctrl_top_tb_top.sv
module wiper_ctrl_top_tb_top;
  localparam int CH   = 2;
  localparam int CW   = 8;
  localparam int GW   = 2;
  localparam int TAPS = 1 << CW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             shdn = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       reg_addr = '0;
  logic [CW-1:0]    wr_data = '0;
  logic [CW-1:0]    rd_data;
  logic [GW-1:0]    gpo;
  logic [CH*TAPS-1:0] tap_sel;
  logic [CH-1:0]    term_a_en;
  logic [CH-1:0]    shdn_sw_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  wiper_ctrl_top #(.CHANNELS(CH), .CODE_W(CW), .GPO_W(GW)) dut_i (
    .clk(clk), .rst(rst), .shdn(shdn), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .gpo(gpo), .tap_sel(tap_sel),
    .term_a_en(term_a_en), .shdn_sw_en(shdn_sw_en)
  );

  task automatic chk(string req, logic [TAPS-1:0] act, logic [TAPS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [TAPS-1:0] onehot(int code);
    return TAPS'(1) << code;
  endfunction

  function automatic logic [TAPS-1:0] taps(int ch);
    return tap_sel[ch*TAPS +: TAPS];
  endfunction

  task automatic do_write(logic [1:0] a, logic [CW-1:0] d);
    @(negedge clk); wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(logic [1:0] a, output logic [CW-1:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic t_reset();
    logic [CW-1:0] v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 ch0 midscale tap", taps(0), onehot(128));
    chk("R1 ch1 midscale tap", taps(1), onehot(128));
    chk("R1 term_a/shdn_sw", TAPS'({term_a_en, shdn_sw_en}), TAPS'(4'b1100));
    chk("R1 gpo cleared", TAPS'(gpo), '0);
    do_read(2'd0, v);
    chk("R1 ch0 latch readback", TAPS'(v), TAPS'(8'h80));
  endtask

  task automatic t_codes();
    logic [CW-1:0] v;
    do_write(2'd0, 8'h00);
    chk("R2 tap unchanged at write edge", taps(0), onehot(128));
    @(negedge clk);
    chk("R3 code 0x00 selects B contact", taps(0), onehot(0));
    do_write(2'd0, 8'hFF);
    @(negedge clk);
    chk("R3 code 0xFF selects top tap", taps(0), onehot(255));
    do_write(2'd1, 8'h5A);
    @(negedge clk);
    chk("R10 ch1 pattern tap", taps(1), onehot(8'h5A));
    chk("R9 ch0 untouched by ch1 write", taps(0), onehot(255));
    do_read(2'd1, v);
    chk("R8 ch1 readback", TAPS'(v), TAPS'(8'h5A));
  endtask

  task automatic t_shutdown();
    logic [CW-1:0] v;
    @(negedge clk); shdn = 1'b1;
    @(negedge clk);
    chk("R4 ch0 taps off", taps(0), '0);
    chk("R4 ch1 taps off", taps(1), '0);
    chk("R4 term_a/shdn_sw", TAPS'({term_a_en, shdn_sw_en}), TAPS'(4'b0011));
    repeat (3) @(negedge clk);
    do_read(2'd0, v);
    chk("R5 ch0 latch kept in shutdown", TAPS'(v), TAPS'(8'hFF));
    shdn = 1'b0;
    @(negedge clk);
    chk("R5 ch0 restored", taps(0), onehot(255));
    chk("R5 ch1 restored", taps(1), onehot(8'h5A));
  endtask

  task automatic t_shdn_write();
    logic [CW-1:0] v;
    @(negedge clk); shdn = 1'b1;
    do_write(2'd0, 8'h33);
    @(negedge clk);
    chk("R6 taps stay off after write", taps(0), '0);
    do_read(2'd0, v);
    chk("R6 readback of new code", TAPS'(v), TAPS'(8'h33));
    shdn = 1'b0;
    @(negedge clk);
    chk("R6 new code after release", taps(0), onehot(8'h33));
  endtask

  task automatic t_gpo();
    logic [CW-1:0] v;
    do_write(2'd2, 8'hFE);
    chk("R7 gpo low bits only", TAPS'(gpo), TAPS'(2'b10));
    do_read(2'd2, v);
    chk("R7 gpo readback zero-extended", TAPS'(v), TAPS'(8'h02));
    do_read(2'd0, v);
    chk("R9 ch0 unchanged by gpo write", TAPS'(v), TAPS'(8'h33));
  endtask

  task automatic t_unused();
    logic [CW-1:0] v;
    do_write(2'd3, 8'h11);
    @(negedge clk);
    do_read(2'd3, v);
    chk("R8 unused address reads zero", TAPS'(v), '0);
    chk("R8 ch0 unaffected by unused write", taps(0), onehot(8'h33));
    chk("R8 ch1 unaffected by unused write", taps(1), onehot(8'h5A));
    chk("R8 gpo unaffected by unused write", TAPS'(gpo), TAPS'(2'b10));
  endtask

  initial begin
    t_reset();
    t_codes();
    t_shutdown();
    t_shdn_write();
    t_gpo();
    t_unused();
    t_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule